// File: doc/BRIEF.md
# Handshaked Shift-Register Packet Link

This block carries byte packets between a host processor and a small device controller across three active-low wires. The host owns two of them, a transfer-active line and an acknowledge line, and updates both with a write to its port B register. The device owns the third, a request line that tells the host it has data waiting. Every byte passes through one 8-bit shift register. When the host is sending, each handshake step appends the shift register to a receive buffer. When the host is receiving, each step loads the next response byte into the shift register.

Bytes are stepped on any change of the {transfer-active, acknowledge} pair, with no serial clock. When the host releases transfer-active, the collected packet is reported with its length. While no transfer is active, an acknowledge toggle is echoed on the request line as a sync handshake. Each handshake event raises a shift-register interrupt flag after a programmable delay counted in 1 µs ticks. The flag is raised at once when the host has set every port B pin to output. The device side loads a response packet through a write port, and the host side reads collected bytes through a synchronous read port.

Top module: `hsl_pkt_link`

## Requirements
- R1: After reset, req_n is 1, sr_irq is 0, pkt_done is 0, pkt_len is 0 and sr_q is 0. The stored previous handshake pair is taken as idle (both lines high).
- R2: In the port B write, bit 5 is transfer-active and bit 4 is acknowledge, both active low. With dir_to_dev=1 and bit 5 low, a write whose pair differs from the previous write appends sr_q to the receive buffer at the next free index. A write that repeats the pair appends nothing and raises no interrupt.
- R3: A host byte that arrives while the receive buffer already holds DEPTH bytes is dropped silently: nothing is stored, the count stays at DEPTH and no interrupt is started.
- R4: A port B write with bit 5 high, when the previous write had bit 5 low, ends the transfer. The next cycle carries a one-cycle pkt_done pulse with pkt_len equal to the byte count, but only if the count is non-zero. The count then returns to 0, and an interrupt is started in every case.
- R5: With dir_to_dev=0 and bit 5 low, a pair change while response bytes are pending loads the next pending byte into sr_q, in buffer order from index 0. With nothing pending, sr_q is left unchanged.
- R6: When the last pending response byte is loaded, req_n goes to 1.
- R7: When a response of non-zero length is started while the previous pair is idle, req_n goes to 0. A non-toggle idle write with bytes still pending also sets req_n to 0.
- R8: With bit 5 high both now and in the previous write, an acknowledge change copies the new acknowledge level to req_n and starts an interrupt.
- R9: sr_irq rises exactly DELAY_US ticks after the event that started it. A new event restarts the full delay.
- R10: With dirb_all_out=1, sr_irq rises on the same clock edge as the event.
- R11: sr_irq_clr clears sr_irq. An interrupt that is raised in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | 1 µs tick enable for the interrupt delay |
| pb_we | input | 1 | Host port B write strobe |
| pb_hs | input | 2 [5:4] | Port B bits 5 (transfer-active) and 4 (acknowledge), active low |
| dir_to_dev | input | 1 | Direction: 1 = host sends to device |
| dirb_all_out | input | 1 | Port B direction register is all ones (immediate interrupt) |
| sr_we | input | 1 | Host write of the shift register |
| sr_wdata | input | DW | Shift register write data |
| sr_irq_clr | input | 1 | Clear the shift-register interrupt flag |
| rsp_wr_en | input | 1 | Response buffer write enable |
| rsp_wr_addr | input | log2(DEPTH) | Response buffer write address |
| rsp_wr_data | input | DW | Response buffer write data |
| rsp_start | input | 1 | Start a response packet |
| rsp_start_len | input | log2(DEPTH)+1 | Response length in bytes (clamped to DEPTH) |
| rx_rd_addr | input | log2(DEPTH) | Receive buffer read address |
| rx_rd_data | output | DW | Receive buffer data, one cycle after the address |
| sr_q | output | DW | Shift register contents |
| req_n | output | 1 | Request line, active low |
| sr_irq | output | 1 | Shift-register interrupt flag |
| pkt_done | output | 1 | One-cycle pulse at the end of a non-empty host packet |
| pkt_len | output | log2(DEPTH)+1 | Length of the packet just ended |

## Verification
Every handshake result (sr_q, req_n, pkt_done, pkt_len, the buffer append, and sr_irq in immediate mode) is registered on the edge that samples the port B write. A receive buffer read returns one edge after its address is applied. In delayed mode sr_irq must stay low up to and including tick edge DELAY_US-1 after the event, and go high at edge DELAY_US. The bench applies every stimulus just after a falling edge and samples just after the next falling edge, so each result is read in the first cycle it is due. The delay is checked cycle by cycle over the whole window, once after a single event and once after a restart three cycles into a running delay.

// File: rtl/hsl_pkg.sv
package hsl_pkg;
  // Port B positions of the two host-driven handshake lines (active low)
  localparam int PB_PROG_BIT = 5;
  localparam int PB_ACK_BIT  = 4;

  typedef struct packed {
    logic prog_n;
    logic ack_n;
  } hs_pair_t;
endpackage

// File: rtl/hsl_byte_ram.sv
module hsl_byte_ram #(
  parameter int DEPTH   = 16,
  parameter int DW      = 8,
  parameter bit SYNC_RD = 1'b1
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] wa,
  input  logic [DW-1:0]            wd,
  input  logic [$clog2(DEPTH)-1:0] ra,
  output logic [DW-1:0]            rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  generate
    if (SYNC_RD) begin : g_sync
      always_ff @(posedge clk) rd <= mem[ra];
    end else begin : g_async
      assign rd = mem[ra];
    end
  endgenerate
endmodule

// File: rtl/hsl_irq_timer.sv
module hsl_irq_timer #(
  parameter int DELAY_US = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic arm,
  input  logic immediate,
  input  logic clr,
  output logic irq
);
  localparam int CW = $clog2(DELAY_US + 1);
  localparam logic [CW-1:0] LOAD = CW'(DELAY_US);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt;
  logic          fire;
  logic          set_now;

  assign fire    = !arm && tick && (cnt == ONE);
  assign set_now = (arm && immediate) || fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      if (arm)                  cnt <= immediate ? '0 : LOAD;
      else if (tick && cnt != '0) cnt <= cnt - ONE;
      if (set_now)              irq <= 1'b1;
      else if (clr)             irq <= 1'b0;
    end
  end

  always_comb begin
    if (!rst) begin
      AST_CNT_IN_RANGE: assert (cnt <= LOAD); // R9
    end
  end

  AST_IRQ_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    (arm && immediate) |=> irq); // R10

  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    (arm && immediate && clr) |=> irq); // R11
endmodule

// File: rtl/hsl_pkt_link.sv
module hsl_pkt_link
  import hsl_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int DW       = 8,
  parameter int DELAY_US = 300
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick_1us,
  input  logic                     pb_we,
  input  logic [5:4]               pb_hs,
  input  logic                     dir_to_dev,
  input  logic                     dirb_all_out,
  input  logic                     sr_we,
  input  logic [DW-1:0]            sr_wdata,
  input  logic                     sr_irq_clr,
  input  logic                     rsp_wr_en,
  input  logic [$clog2(DEPTH)-1:0] rsp_wr_addr,
  input  logic [DW-1:0]            rsp_wr_data,
  input  logic                     rsp_start,
  input  logic [$clog2(DEPTH):0]   rsp_start_len,
  input  logic [$clog2(DEPTH)-1:0] rx_rd_addr,
  output logic [DW-1:0]            rx_rd_data,
  output logic [DW-1:0]            sr_q,
  output logic                     req_n,
  output logic                     sr_irq,
  output logic                     pkt_done,
  output logic [$clog2(DEPTH):0]   pkt_len
);
  localparam int AW = $clog2(DEPTH);
  localparam int IW = AW + 1;
  localparam logic [IW-1:0] DEPTH_V = IW'(DEPTH);
  localparam logic [IW-1:0] ONE_V   = IW'(1);

  hs_pair_t      cur, last;
  logic [IW-1:0] rx_cnt, rsp_idx, rsp_len, start_len;
  logic [DW-1:0] rsp_rd;
  logic pair_chg, in_xfer, idle_upd, rsp_pend;
  logic send_step, recv_step, last_byte, sync_tog, xfer_end, idle_pend, arm;

  assign cur.prog_n = pb_hs[PB_PROG_BIT];
  assign cur.ack_n  = pb_hs[PB_ACK_BIT];
  assign start_len  = (rsp_start_len > DEPTH_V) ? DEPTH_V : rsp_start_len;

  // Handshake event decode
  assign pair_chg  = (cur != last);
  assign in_xfer   = pb_we && !cur.prog_n;
  assign idle_upd  = pb_we && cur.prog_n;
  assign rsp_pend  = (rsp_idx < rsp_len);
  assign send_step = in_xfer && dir_to_dev && pair_chg && (rx_cnt < DEPTH_V);
  assign recv_step = in_xfer && !dir_to_dev && pair_chg && rsp_pend;
  assign last_byte = recv_step && ((rsp_idx + ONE_V) == rsp_len);
  assign sync_tog  = idle_upd && last.prog_n && (cur.ack_n != last.ack_n);
  assign xfer_end  = idle_upd && !sync_tog && !last.prog_n;
  assign idle_pend = (idle_upd && !sync_tog && rsp_pend) ||
                     (rsp_start && last.prog_n && (start_len != '0));
  assign arm       = send_step || recv_step || sync_tog || xfer_end || rsp_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      last     <= '{prog_n: 1'b1, ack_n: 1'b1};
      rx_cnt   <= '0;
      rsp_idx  <= '0;
      rsp_len  <= '0;
      req_n    <= 1'b1;
      sr_q     <= '0;
      pkt_done <= 1'b0;
      pkt_len  <= '0;
    end else begin
      pkt_done <= 1'b0;
      if (pb_we) last <= cur;

      if (send_step) rx_cnt <= rx_cnt + ONE_V;
      if (xfer_end) begin
        rx_cnt <= '0;
        if (rx_cnt != '0) begin
          pkt_done <= 1'b1;
          pkt_len  <= rx_cnt;
        end
      end

      if (recv_step)  sr_q <= rsp_rd;
      else if (sr_we) sr_q <= sr_wdata;

      if (rsp_start) begin
        rsp_idx <= '0;
        rsp_len <= start_len;
      end else if (recv_step) begin
        rsp_idx <= rsp_idx + ONE_V;
      end

      if (last_byte)      req_n <= 1'b1;
      else if (sync_tog)  req_n <= cur.ack_n;
      else if (idle_pend) req_n <= 1'b0;
    end
  end

  // Host-to-device bytes: block RAM style, registered read
  hsl_byte_ram #(.DEPTH(DEPTH), .DW(DW), .SYNC_RD(1'b1)) u_rx_ram (
    .clk (clk),
    .we  (send_step),
    .wa  (rx_cnt[AW-1:0]),
    .wd  (sr_q),
    .ra  (rx_rd_addr),
    .rd  (rx_rd_data)
  );

  // Response bytes: read in the same cycle as the handshake step
  hsl_byte_ram #(.DEPTH(DEPTH), .DW(DW), .SYNC_RD(1'b0)) u_rsp_ram (
    .clk (clk),
    .we  (rsp_wr_en),
    .wa  (rsp_wr_addr),
    .wd  (rsp_wr_data),
    .ra  (rsp_idx[AW-1:0]),
    .rd  (rsp_rd)
  );

  hsl_irq_timer #(.DELAY_US(DELAY_US)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_1us),
    .arm       (arm),
    .immediate (dirb_all_out),
    .clr       (sr_irq_clr),
    .irq       (sr_irq)
  );

  always_comb begin
    if (!rst) begin
      AST_RX_NO_OVERFLOW: assert (rx_cnt <= DEPTH_V); // R3
      AST_RSP_IDX_BOUND: assert (rsp_idx <= rsp_len); // R5
    end
  end

  AST_DONE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> (pkt_len != '0)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pkt_done |=> !pkt_done); // R4

  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    last_byte |=> req_n); // R6
endmodule

// File: tb/hsl_pkt_link_tb.sv
module hsl_pkt_link_tb;
  localparam int DEPTH = 4;
  localparam int DW    = 8;
  localparam int DLY   = 5;
  localparam int AW    = $clog2(DEPTH);
  localparam int IW    = AW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1us = 1'b1;
  logic pb_we = 1'b0;
  logic [5:4] pb_hs = 2'b11;
  logic dir_to_dev = 1'b1;
  logic dirb_all_out = 1'b1;
  logic sr_we = 1'b0;
  logic [DW-1:0] sr_wdata = '0;
  logic sr_irq_clr = 1'b0;
  logic rsp_wr_en = 1'b0;
  logic [AW-1:0] rsp_wr_addr = '0;
  logic [DW-1:0] rsp_wr_data = '0;
  logic rsp_start = 1'b0;
  logic [IW-1:0] rsp_start_len = '0;
  logic [AW-1:0] rx_rd_addr = '0;
  logic [DW-1:0] rx_rd_data, sr_q;
  logic req_n, sr_irq, pkt_done;
  logic [IW-1:0] pkt_len;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  hsl_pkt_link #(.DEPTH(DEPTH), .DW(DW), .DELAY_US(DLY)) u_dut (
    .clk(clk), .rst(rst), .tick_1us(tick_1us), .pb_we(pb_we), .pb_hs(pb_hs),
    .dir_to_dev(dir_to_dev), .dirb_all_out(dirb_all_out), .sr_we(sr_we),
    .sr_wdata(sr_wdata), .sr_irq_clr(sr_irq_clr), .rsp_wr_en(rsp_wr_en),
    .rsp_wr_addr(rsp_wr_addr), .rsp_wr_data(rsp_wr_data), .rsp_start(rsp_start),
    .rsp_start_len(rsp_start_len), .rx_rd_addr(rx_rd_addr), .rx_rd_data(rx_rd_data),
    .sr_q(sr_q), .req_n(req_n), .sr_irq(sr_irq), .pkt_done(pkt_done), .pkt_len(pkt_len)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // All tasks start just after a falling edge and return just after the next one.
  task automatic pb_write(input logic [7:0] v, input logic clr);
    pb_we = 1'b1; pb_hs = v[5:4]; sr_irq_clr = clr;
    @(negedge clk);
    pb_we = 1'b0; sr_irq_clr = 1'b0;
  endtask

  task automatic sr_write(input logic [7:0] v);
    sr_we = 1'b1; sr_wdata = v;
    @(negedge clk);
    sr_we = 1'b0;
  endtask

  task automatic irq_clear();
    sr_irq_clr = 1'b1;
    @(negedge clk);
    sr_irq_clr = 1'b0;
  endtask

  task automatic rsp_go(input int len);
    rsp_start = 1'b1; rsp_start_len = IW'(len);
    @(negedge clk);
    rsp_start = 1'b0;
  endtask

  task automatic rx_read(input int a, output logic [7:0] d);
    rx_rd_addr = AW'(a);
    @(negedge clk);
    d = rx_rd_data;
  endtask

  function automatic logic [7:0] step_val(input int i);
    return (i % 2 == 0) ? 8'h10 : 8'h00;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 req_n", req_n, 1);
    chk("R1 sr_irq", sr_irq, 0);
    chk("R1 pkt_done", pkt_done, 0);
    chk("R1 pkt_len", pkt_len, 0);
    chk("R1 sr_q", sr_q, 0);

    // Host-to-device sweep over packet lengths, immediate interrupt mode
    dir_to_dev = 1'b1;
    for (int n = 1; n <= DEPTH + 2; n++) begin
      for (int i = 0; i < n; i++) begin
        sr_write(8'(n * 16 + i));
        pb_write(step_val(i), 1'b0);
        if (i < DEPTH) chk("R2 step raises irq", sr_irq, 1);
        else           chk("R3 dropped byte raises no irq", sr_irq, 0);
        irq_clear();
        if (n == 2 && i == 0) begin
          sr_write(8'hEE);
          pb_write(step_val(i), 1'b0);
          chk("R2 repeated pair no irq", sr_irq, 0);
          sr_write(8'(n * 16 + i));
        end
      end
      pb_write(8'h30, 1'b0);
      chk("R4 pkt_done", pkt_done, 1);
      chk("R4 R3 pkt_len", pkt_len, (n < DEPTH) ? n : DEPTH);
      chk("R4 end irq", sr_irq, 1);
      @(negedge clk);
      chk("R4 pkt_done single cycle", pkt_done, 0);
      irq_clear();
      for (int i = 0; i < ((n < DEPTH) ? n : DEPTH); i++) begin
        rx_read(i, d);
        chk("R2 R3 rx byte", d, 8'(n * 16 + i));
      end
    end

    // Empty transfer: no packet report, interrupt still raised
    dir_to_dev = 1'b0;
    pb_write(8'h10, 1'b0);
    irq_clear();
    pb_write(8'h30, 1'b0);
    chk("R4 empty no pkt_done", pkt_done, 0);
    chk("R4 empty end irq", sr_irq, 1);
    irq_clear();

    // Response bytes
    for (int a = 0; a < DEPTH; a++) begin
      rsp_wr_en = 1'b1; rsp_wr_addr = AW'(a); rsp_wr_data = 8'(8'hA0 + a);
      @(negedge clk);
    end
    rsp_wr_en = 1'b0;
    for (int m = 1; m <= DEPTH; m++) begin
      rsp_go(m);
      chk("R7 req on start", req_n, 0);
      irq_clear();
      for (int i = 0; i < m; i++) begin
        pb_write(step_val(i), 1'b0);
        chk("R5 sr load", sr_q, 8'(8'hA0 + i));
        chk("R6 req after load", req_n, (i == m - 1) ? 1 : 0);
        irq_clear();
      end
      pb_write(step_val(m), 1'b0);
      chk("R5 no pending keeps sr", sr_q, 8'(8'hA0 + m - 1));
      chk("R5 no pending no irq", sr_irq, 0);
      pb_write(8'h30, 1'b0);
      chk("R6 req stays high", req_n, 1);
      irq_clear();
    end

    // Sync toggle and idle pending
    rsp_go(2);
    irq_clear();
    pb_write(8'h20, 1'b0);
    chk("R8 req copies ack low", req_n, 0);
    chk("R8 sync irq", sr_irq, 1);
    irq_clear();
    pb_write(8'h30, 1'b0);
    chk("R8 req copies ack high", req_n, 1);
    irq_clear();
    pb_write(8'h30, 1'b0);
    chk("R7 idle pending req low", req_n, 0);
    chk("R7 idle write no irq", sr_irq, 0);

    // Delayed interrupt
    dirb_all_out = 1'b0;
    pb_write(8'h20, 1'b0);
    for (int k = 0; k <= DLY; k++) begin
      chk("R9 delay window", sr_irq, (k == DLY) ? 1 : 0);
      if (k < DLY) @(negedge clk);
    end
    irq_clear();
    pb_write(8'h30, 1'b0);
    chk("R9 restart first", sr_irq, 0);
    @(negedge clk);
    @(negedge clk);
    pb_write(8'h20, 1'b0);
    for (int k = 0; k <= DLY; k++) begin
      chk("R9 restart window", sr_irq, (k == DLY) ? 1 : 0);
      if (k < DLY) @(negedge clk);
    end

    // Set beats clear, then clear works
    dirb_all_out = 1'b1;
    pb_write(8'h30, 1'b1);
    chk("R10 R11 set wins over clear", sr_irq, 1);
    irq_clear();
    chk("R11 clear", sr_irq, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule